// File: doc/BRIEF.md
# Minute-Second Counter with Selectable Periodic Interrupt

This block keeps a single running count of minutes and seconds, from 00:00 to 59:59, and then wraps. A time-base divider supplies a 2 Hz tick enable. Every second tick advances the seconds field, and a carry out of 59 seconds advances the minutes field. Software reads the fields and the control and status state through a small register port. One bus cycle is a valid strobe with a write qualifier, an address and write data. Read data is combinational from the address.

Software can preset the two time fields, but only through a one-shot unlock. The bus write just before the time write must put the key 0x5A into the unlock register. A preset value above 59 is refused and raises an error flag. One interrupt source is active at a time, chosen from four intervals (half second, one second, half minute, one minute). It sets a sticky flag that drives the interrupt output until software clears it.

Register map (address: content): 0 seconds, 1 minutes, 2 unlock key (reads back bit 0 = unlocked), 3 control (bits 1:0 interval select), 4 status (bit 0 interrupt flag, bit 1 error flag, write 1 to clear).

Top module: `minsec_rtc`

## Requirements
- R1: After synchronous reset, seconds and minutes read 0, the control register reads 0, both status flags are 0 and the interrupt output is low. Neither field ever holds a value above 59.
- R2: The first tick after reset does not change the count. After that, seconds advance by one on every second tick.
- R3: An advance from 59 seconds sets seconds to 0 and increments minutes. An advance from 59:59 gives 00:00.
- R4: A write to address 0 or 1 is accepted only when the bus write just before it wrote 0x5A to address 2. A write of any other value or to any other address clears the unlock, and reads leave it unchanged.
- R5: A write to address 0 or 1 without the unlock leaves both fields unchanged.
- R6: An unlocked write of a value above 59 leaves the field unchanged and sets status bit 1. Writing 1 to status bit 1 clears it.
- R7: Control bits 1:0 choose the interrupt event. 0 is every tick. 1 is every seconds advance. 2 is an advance that makes seconds 0 or 30. 3 is an advance that makes seconds 0.
- R8: Status bit 0 (the interrupt output) stays set until software writes 1 to it. An event in the same cycle as that clear leaves it set.
- R9: In a cycle where a time write is accepted, the tick does not advance the count, but the tick phase still toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_2hz | input | 1 | Half-second tick enable, one cycle wide |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| irq | output | 1 | Periodic interrupt flag |

## Verification
The bench uses the default limit of 59 and key 0x5A. Presetting fields through the unlock brings the 59-second carry and the 59:59 wrap within a few ticks. It also reaches the 29-to-30 half-minute mark without counting through a full hour. A tick that lands in the same cycle as a time write or a flag clear exercises the two collisions the block has to resolve.

// File: rtl/minsec_pkg.sv
package minsec_pkg;
  localparam int unsigned FIELD_W = 6;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned ADDR_W  = 3;

  localparam logic [ADDR_W-1:0] A_SEC  = 3'd0;
  localparam logic [ADDR_W-1:0] A_MIN  = 3'd1;
  localparam logic [ADDR_W-1:0] A_KEY  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd4;

  typedef enum logic [1:0] {
    IV_HALF    = 2'd0,
    IV_SEC     = 2'd1,
    IV_HALFMIN = 2'd2,
    IV_MIN     = 2'd3
  } ival_e;

  // value fits in a time field whose top count is lim
  function automatic logic fits(input logic [DATA_W-1:0] v, input logic [FIELD_W-1:0] lim);
    return v <= {{(DATA_W-FIELD_W){1'b0}}, lim};
  endfunction

  // modulo (lim+1) increment
  function automatic logic [FIELD_W-1:0] bump(input logic [FIELD_W-1:0] v,
                                              input logic [FIELD_W-1:0] lim);
    return (v == lim) ? '0 : v + 1'b1;
  endfunction
endpackage

// File: rtl/ms_phase.sv
module ms_phase (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic half_evt,
  output logic sec_evt
);
  logic half_q;

  always_ff @(posedge clk) begin
    if (rst)       half_q <= 1'b0;
    else if (tick) half_q <= ~half_q;
  end

  assign half_evt = tick;
  assign sec_evt  = tick & half_q;   // R2: every second tick
endmodule

// File: rtl/ms_guard.sv
module ms_guard import minsec_pkg::*; #(
  parameter logic [FIELD_W-1:0] LIMIT = 6'd59,
  parameter logic [DATA_W-1:0]  KEY   = 8'h5A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ld_sec,
  output logic              ld_min,
  output logic              bad_val,
  output logic              unlocked
);
  logic val_ok, wr_time;

  assign val_ok  = fits(wdata, LIMIT);
  assign wr_time = wr_en & ((addr == A_SEC) | (addr == A_MIN));
  assign ld_sec  = wr_en & (addr == A_SEC) & unlocked & val_ok;   // R4 R5
  assign ld_min  = wr_en & (addr == A_MIN) & unlocked & val_ok;
  assign bad_val = wr_time & unlocked & ~val_ok;                  // R6

  // one-shot: every bus write re-arms or disarms
  always_ff @(posedge clk) begin
    if (rst)        unlocked <= 1'b0;
    else if (wr_en) unlocked <= (addr == A_KEY) && (wdata == KEY);
  end
endmodule

// File: rtl/ms_time.sv
module ms_time import minsec_pkg::*; #(
  parameter logic [FIELD_W-1:0] LIMIT = 6'd59
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sec_evt,
  input  logic               ld_sec,
  input  logic               ld_min,
  input  logic [FIELD_W-1:0] ld_val,
  output logic [FIELD_W-1:0] sec_q,
  output logic [FIELD_W-1:0] min_q,
  output logic [FIELD_W-1:0] sec_nx,
  output logic               step
);
  assign step   = sec_evt & ~(ld_sec | ld_min);   // R9
  assign sec_nx = bump(sec_q, LIMIT);

  always_ff @(posedge clk) begin
    if (rst)         sec_q <= '0;
    else if (ld_sec) sec_q <= ld_val;
    else if (step)   sec_q <= sec_nx;
  end

  always_ff @(posedge clk) begin
    if (rst)                          min_q <= '0;
    else if (ld_min)                  min_q <= ld_val;
    else if (step && sec_q == LIMIT)  min_q <= bump(min_q, LIMIT);   // R3
  end
endmodule

// File: rtl/ms_irq.sv
module ms_irq import minsec_pkg::*; #(
  parameter logic [FIELD_W-1:0] LIMIT = 6'd59
) (
  input  logic               clk,
  input  logic               rst,
  input  ival_e              sel,
  input  logic               half_evt,
  input  logic               step,
  input  logic [FIELD_W-1:0] sec_nx,
  input  logic               clr,
  output logic               evt,
  output logic               flag
);
  localparam logic [FIELD_W-1:0] HALF_MARK = FIELD_W'((int'(LIMIT) + 1) / 2);

  always_comb begin
    unique case (sel)
      IV_HALF:    evt = half_evt;
      IV_SEC:     evt = step;
      IV_HALFMIN: evt = step & ((sec_nx == '0) | (sec_nx == HALF_MARK));
      default:    evt = step & (sec_nx == '0);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else     flag <= evt | (flag & ~clr);   // R8: event beats clear
  end
endmodule

// File: rtl/minsec_rtc.sv
module minsec_rtc import minsec_pkg::*; #(
  parameter logic [FIELD_W-1:0] LIMIT = 6'd59,
  parameter logic [DATA_W-1:0]  KEY   = 8'h5A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_2hz,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int unsigned PAD = DATA_W - FIELD_W;

  logic               wr_en, half_evt, sec_evt, step;
  logic               ld_sec, ld_min, bad_val, unlocked;
  logic               clr_irq, clr_err, err_q, irq_evt;
  logic [FIELD_W-1:0] sec_q, min_q, sec_nx;
  ival_e              sel_q;

  assign wr_en   = bus_valid & bus_write;
  assign clr_irq = wr_en & (bus_addr == A_STAT) & bus_wdata[0];
  assign clr_err = wr_en & (bus_addr == A_STAT) & bus_wdata[1];

  ms_phase u_phase (
    .clk(clk), .rst(rst), .tick(tick_2hz),
    .half_evt(half_evt), .sec_evt(sec_evt)
  );

  ms_guard #(.LIMIT(LIMIT), .KEY(KEY)) u_guard (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(bus_addr), .wdata(bus_wdata),
    .ld_sec(ld_sec), .ld_min(ld_min), .bad_val(bad_val), .unlocked(unlocked)
  );

  ms_time #(.LIMIT(LIMIT)) u_time (
    .clk(clk), .rst(rst), .sec_evt(sec_evt), .ld_sec(ld_sec), .ld_min(ld_min),
    .ld_val(bus_wdata[FIELD_W-1:0]), .sec_q(sec_q), .min_q(min_q),
    .sec_nx(sec_nx), .step(step)
  );

  ms_irq #(.LIMIT(LIMIT)) u_irq (
    .clk(clk), .rst(rst), .sel(sel_q), .half_evt(half_evt), .step(step),
    .sec_nx(sec_nx), .clr(clr_irq), .evt(irq_evt), .flag(irq)
  );

  always_ff @(posedge clk) begin
    if (rst)                               sel_q <= IV_HALF;
    else if (wr_en && bus_addr == A_CTRL)  sel_q <= ival_e'(bus_wdata[1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= bad_val | (err_q & ~clr_err);   // R6
  end

  always_comb begin
    unique case (bus_addr)
      A_SEC:   bus_rdata = {{PAD{1'b0}}, sec_q};
      A_MIN:   bus_rdata = {{PAD{1'b0}}, min_q};
      A_KEY:   bus_rdata = {{(DATA_W-1){1'b0}}, unlocked};
      A_CTRL:  bus_rdata = {{(DATA_W-2){1'b0}}, sel_q};
      A_STAT:  bus_rdata = {{(DATA_W-2){1'b0}}, err_q, irq};
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/minsec_rtc_chk.sv
module minsec_rtc_chk import minsec_pkg::*; #(
  parameter logic [FIELD_W-1:0] LIMIT = 6'd59
) (
  input logic               clk,
  input logic               rst,
  input logic [FIELD_W-1:0] sec,
  input logic [FIELD_W-1:0] min,
  input logic               step,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  addr,
  input logic               unlocked,
  input logic               bad_val,
  input logic               err,
  input logic               evt,
  input logic               clr_irq,
  input logic               irq
);
  AST_FIELDS_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (sec <= LIMIT) && (min <= LIMIT)); // R1

  AST_FULL_WRAP: assert property (@(posedge clk) disable iff (rst)
    (step && sec == LIMIT && min == LIMIT) |=> (sec == '0 && min == '0)); // R3

  AST_UNLOCK_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr != A_KEY) |=> !unlocked); // R4

  AST_LOCKED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_SEC && !unlocked && !step) |=> (sec == $past(sec))); // R5

  AST_BAD_VALUE_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    (bad_val && !step) |=> (err && sec == $past(sec) && min == $past(min))); // R6

  AST_EVENT_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    evt |=> irq); // R8

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq && !clr_irq) |=> irq); // R8
endmodule

bind minsec_rtc minsec_rtc_chk #(.LIMIT(LIMIT)) u_chk (
  .clk(clk), .rst(rst), .sec(sec_q), .min(min_q), .step(step),
  .wr_en(wr_en), .addr(bus_addr), .unlocked(unlocked), .bad_val(bad_val),
  .err(err_q), .evt(irq_evt), .clr_irq(clr_irq), .irq(irq)
);

// File: tb/minsec_rtc_tb.sv
`timescale 1ns/1ps
module minsec_rtc_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_2hz = 1'b0;
  logic       bus_valid = 1'b0;
  logic       bus_write = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    bit    pin;      // 1: irq pin, 0: read data
    int    addr;
    int    exp;
    string tag;
  } item_t;

  item_t sb_q[$];
  event  sb_ev;

  always #2.5 clk = ~clk;

  minsec_rtc u_dut (
    .clk(clk), .rst(rst), .tick_2hz(tick_2hz), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  // monitor: pops expectations and compares with what the outputs show
  initial begin
    forever begin
      @(sb_ev);
      while (sb_q.size() != 0) begin
        item_t it;
        int act;
        it = sb_q.pop_front();
        act = it.pin ? int'(irq) : int'(bus_rdata);
        checks++;
        if (act != it.exp) begin
          failures++;
          $display("FAIL %s addr=%0d actual=%0d expected=%0d", it.tag, it.addr, act, it.exp);
        end
      end
    end
  end

  // drivers: each task starts just after a falling edge and ends on the next
  task automatic wr(input int a, input int d, input bit t = 1'b0);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 3'(a); bus_wdata = 8'(d);
    tick_2hz = t;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; tick_2hz = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_2hz = 1'b1;
      @(negedge clk);
      tick_2hz = 1'b0;
    end
  endtask

  task automatic unlock();
    wr(2, 8'h5A);
  endtask

  task automatic rd_exp(input int a, input int e, input string tag);
    item_t it;
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 3'(a);
    #1;
    it.pin = 1'b0; it.addr = a; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    ->sb_ev;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic irq_exp(input int e, input string tag);
    item_t it;
    #1;
    it.pin = 1'b1; it.addr = -1; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    ->sb_ev;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state
    rd_exp(0, 0, "R1 seconds after reset");
    rd_exp(1, 0, "R1 minutes after reset");
    rd_exp(3, 0, "R1 control after reset");
    rd_exp(4, 0, "R1 status after reset");
    irq_exp(0, "R1 irq after reset");

    // one-second interval, first tick is only a half phase
    wr(3, 1);
    ticks(1);
    rd_exp(0, 0, "R2 first tick does not advance");
    irq_exp(0, "R7 sel=1 no event on half tick");
    ticks(1);
    rd_exp(0, 1, "R2 second tick advances");
    irq_exp(1, "R7 sel=1 event on advance");
    rd_exp(1, 0, "R8 idle cycle");
    irq_exp(1, "R8 flag stays set");
    wr(4, 1);
    irq_exp(0, "R8 write one clears");

    // half-second interval
    wr(3, 0);
    ticks(1);
    irq_exp(1, "R7 sel=0 fires on every tick");
    rd_exp(0, 1, "R2 half tick keeps seconds");
    wr(4, 1);

    // minute interval and wraps
    wr(3, 3);
    unlock(); wr(0, 58);
    rd_exp(0, 58, "R4 unlocked seconds write");
    unlock(); wr(1, 59);
    rd_exp(1, 59, "R4 unlocked minutes write");
    ticks(1);
    rd_exp(0, 59, "R2 advance to 59");
    irq_exp(0, "R7 sel=3 quiet at 59");
    ticks(2);
    rd_exp(0, 0, "R3 seconds wrap at 59:59");
    rd_exp(1, 0, "R3 minutes wrap at 59:59");
    irq_exp(1, "R7 sel=3 fires when seconds reach 0");
    unlock(); wr(0, 59);
    unlock(); wr(1, 5);
    ticks(2);
    rd_exp(0, 0, "R3 seconds carry");
    rd_exp(1, 6, "R3 minute increment on carry");
    wr(4, 1);

    // protection
    wr(0, 10);
    rd_exp(0, 0, "R5 locked write ignored");
    unlock(); wr(3, 3); wr(0, 10);
    rd_exp(0, 0, "R4 intervening write clears unlock");
    wr(2, 8'h5B); wr(0, 10);
    rd_exp(0, 0, "R4 wrong key does not unlock");
    unlock(); rd_exp(2, 1, "R4 key read back"); wr(0, 7);
    rd_exp(0, 7, "R4 read does not clear unlock");

    // range errors
    wr(4, 3);
    unlock(); wr(0, 60);
    rd_exp(0, 7, "R6 seconds 60 rejected");
    rd_exp(4, 2, "R6 error flag set");
    wr(4, 2);
    rd_exp(4, 0, "R6 error flag cleared");
    unlock(); wr(1, 63);
    rd_exp(1, 6, "R6 minutes 63 rejected");
    rd_exp(4, 2, "R6 error flag set again");
    wr(4, 2);

    // half-minute interval
    wr(3, 2);
    unlock(); wr(0, 28);
    wr(4, 1);
    ticks(2);
    rd_exp(0, 29, "R2 advance to 29");
    irq_exp(0, "R7 sel=2 quiet at 29");
    ticks(2);
    irq_exp(1, "R7 sel=2 fires at 30");
    wr(4, 1);
    ticks(2);
    irq_exp(0, "R7 sel=2 quiet at 31");

    // event versus clear in the same cycle
    wr(3, 0);
    ticks(1);
    irq_exp(1, "R7 sel=0 tick event");
    wr(4, 1, 1'b1);
    irq_exp(1, "R8 event wins over clear");
    rd_exp(0, 32, "R2 advance during clear");
    wr(4, 1);
    irq_exp(0, "R8 clear without event");

    // time write collides with an advancing tick
    ticks(1);
    unlock(); wr(0, 10, 1'b1);
    rd_exp(0, 10, "R9 write wins over advance");
    rd_exp(1, 6, "R9 minutes untouched");
    ticks(2);
    rd_exp(0, 11, "R9 phase still toggled");

    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule